// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between a processor core and its data cache and keeps the core's memory traffic within total-store-ordering rules. Stores from the core go into a small circular queue and leave for the cache one at a time, oldest first. Loads do not wait behind queued stores. If the load's word address is not in the queue, it goes straight to the cache read port. If it is in the queue, the newest queued value for that address is returned and the cache is not read.

Fence and atomic swap requests use a separate request channel. Neither is acknowledged until the queue has emptied. An atomic swap then reads its word from the cache and writes the new value to the same word, and no other core access runs in between. Stores and loads are held off for as long as such a request is pending. Every access is a full 32-bit word addressed by word. The cache write port can refuse a write for a cycle. The cache read port returns its data exactly one cycle after the request.

Top module: `tsq_store_queue`

## Requirements
- R1: Queued stores are offered on the cache write port oldest first. An offer stays stable while cw_ready is low, and one entry leaves in each cycle where cw_valid and cw_ready are both high.
- R2: With DEPTH entries queued (default 4), st_ready is low and no further store is taken.
- R3: A load whose word address matches no queued entry raises cr_valid with that address in its accept cycle. One cycle later ld_rvalid is high and ld_rdata equals the cache data.
- R4: A load whose address matches a queued entry keeps cr_valid low. One cycle later it returns the queued data.
- R5: When several queued entries match a load, the most recently accepted one supplies the data.
- R6: A load is accepted and completes while older stores to other addresses are still queued.
- R7: A fence (sync_rmw=0) keeps sync_ready low until the queue is empty. While sync_valid is high, st_ready and ld_ready are low.
- R8: An atomic swap (sync_rmw=1) first waits for the queue to empty. It then reads sync_addr on the read port, writes sync_wdata to sync_addr on the write port, and completes with sync_ready high and sync_rdata equal to the old word.
- R9: sb_empty is high exactly when no entry is queued. drain_done is high for one cycle, exactly in the cycle where sync_valid and sync_ready are both high.
- R10: After reset the queue is empty, cw_valid is low, ld_rvalid is low and st_ready is high.
- R11: A load searches only the entries queued before its cycle. A store accepted in the same cycle is not forwarded to it. An entry leaving for the cache in the load's cycle is still forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted when high with st_valid |
| st_addr | input | 30 | Store word address |
| st_data | input | 32 | Store data |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load accepted when high with ld_valid |
| ld_addr | input | 30 | Load word address |
| ld_rvalid | output | 1 | Load response valid, one cycle after accept |
| ld_rdata | output | 32 | Load response data |
| sync_valid | input | 1 | Fence or atomic swap request valid |
| sync_rmw | input | 1 | 1 selects atomic swap, 0 selects fence |
| sync_addr | input | 30 | Swap word address |
| sync_wdata | input | 32 | Swap new value |
| sync_ready | output | 1 | Request complete |
| sync_rdata | output | 32 | Old word returned by a swap |
| cw_valid | output | 1 | Cache write request |
| cw_ready | input | 1 | Cache takes the write |
| cw_addr | output | 30 | Cache write word address |
| cw_data | output | 32 | Cache write data |
| cr_valid | output | 1 | Cache read request |
| cr_addr | output | 30 | Cache read word address |
| cr_rdata | input | 32 | Cache read data, one cycle after cr_valid |
| sb_empty | output | 1 | No entry queued |
| drain_done | output | 1 | Pulse when a fence or swap completes |

## Verification
Two operations can share a cycle: a load that forwards from an entry, and the drain of that same entry to the cache. A load can also share a cycle with a store to the same address. The bench provokes the first case by raising cw_ready in the cycle where a load hits the head entry. It expects the queued value, cr_valid low and the queue empty afterwards. It provokes the second case by presenting the store and the load together to an empty queue. Here it expects the load to read the cache and return the cache's old word.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    parameter int unsigned WORD_W = 32;
    parameter int unsigned ADDR_W = 30;

    typedef logic [ADDR_W-1:0] waddr_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        waddr_t addr;
        word_t  data;
    } sb_entry_t;

    typedef enum logic [1:0] {
        SY_IDLE = 2'd0,
        SY_READ = 2'd1,
        SY_WRITE = 2'd2
    } sync_state_e;

    function automatic sb_entry_t make_entry(input waddr_t a, input word_t d);
        sb_entry_t e;
        e.addr = a;
        e.data = d;
        return e;
    endfunction

endpackage

// File: rtl/tsq_fifo.sv
module tsq_fifo
    import tsq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = $clog2(DEPTH),
    localparam int unsigned CW = PW + 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push_i,
    input  sb_entry_t push_entry_i,
    input  logic      pop_i,
    output sb_entry_t slots_o [DEPTH],
    output logic [PW-1:0] head_o,
    output logic [CW-1:0] count_o,
    output sb_entry_t head_entry_o,
    output logic      full_o,
    output logic      empty_o
);

    sb_entry_t     store_q [DEPTH];
    logic [PW-1:0] head_q;
    logic [PW-1:0] tail_q;
    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (push_i) begin
            store_q[tail_q] <= push_entry_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push_i) tail_q <= tail_q + PW'(1);
            if (pop_i)  head_q <= head_q + PW'(1);
            case ({push_i, pop_i})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    assign slots_o      = store_q;
    assign head_o       = head_q;
    assign count_o      = count_q;
    assign head_entry_o = store_q[head_q];
    assign full_o       = (count_q == CW'(DEPTH));
    assign empty_o      = (count_q == '0);

endmodule

// File: rtl/tsq_match.sv
module tsq_match
    import tsq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = $clog2(DEPTH),
    localparam int unsigned CW = PW + 1
) (
    input  sb_entry_t     slots_i [DEPTH],
    input  logic [PW-1:0] head_i,
    input  logic [CW-1:0] count_i,
    input  waddr_t        addr_i,
    output logic          hit_o,
    output word_t         data_o
);

    logic  match_vec [DEPTH];
    word_t age_data  [DEPTH];

    // k counts from the oldest entry (k=0) toward the newest
    for (genvar k = 0; k < DEPTH; k++) begin : g_age
        logic [PW-1:0] slot;
        assign slot         = head_i + PW'(k);
        assign match_vec[k] = (CW'(k) < count_i) && (slots_i[slot].addr == addr_i);
        assign age_data[k]  = slots_i[slot].data;
    end

    // later (younger) matches override earlier ones
    always_comb begin
        hit_o  = 1'b0;
        data_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (match_vec[k]) begin
                hit_o  = 1'b1;
                data_o = age_data[k];
            end
        end
    end

endmodule

// File: rtl/tsq_sync_ctl.sv
module tsq_sync_ctl
    import tsq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sync_valid_i,
    input  logic  sync_rmw_i,
    input  logic  buf_empty_i,
    input  logic  cw_ready_i,
    input  word_t cr_rdata_i,
    output logic  sync_ready_o,
    output logic  drain_done_o,
    output logic  rmw_rd_o,
    output logic  rmw_wr_o,
    output word_t old_word_o
);

    sync_state_e state_q;
    sync_state_e state_d;
    word_t       old_q;

    always_comb begin
        state_d      = state_q;
        sync_ready_o = 1'b0;
        rmw_rd_o     = 1'b0;
        rmw_wr_o     = 1'b0;
        case (state_q)
            SY_IDLE: begin
                if (sync_valid_i && buf_empty_i) begin
                    if (sync_rmw_i) begin
                        rmw_rd_o = 1'b1;
                        state_d  = SY_READ;
                    end else begin
                        sync_ready_o = 1'b1;
                    end
                end
            end
            SY_READ: begin
                state_d = SY_WRITE;
            end
            SY_WRITE: begin
                rmw_wr_o = 1'b1;
                if (cw_ready_i) begin
                    sync_ready_o = 1'b1;
                    state_d      = SY_IDLE;
                end
            end
            default: state_d = SY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SY_IDLE;
            old_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SY_READ) old_q <= cr_rdata_i;
        end
    end

    assign drain_done_o = sync_ready_o;
    assign old_word_o   = old_q;

endmodule

// File: rtl/tsq_store_queue.sv
module tsq_store_queue
    import tsq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = $clog2(DEPTH),
    localparam int unsigned CW = PW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [WORD_W-1:0] st_data,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_rvalid,
    output logic [WORD_W-1:0] ld_rdata,
    input  logic              sync_valid,
    input  logic              sync_rmw,
    input  logic [ADDR_W-1:0] sync_addr,
    input  logic [WORD_W-1:0] sync_wdata,
    output logic              sync_ready,
    output logic [WORD_W-1:0] sync_rdata,
    output logic              cw_valid,
    input  logic              cw_ready,
    output logic [ADDR_W-1:0] cw_addr,
    output logic [WORD_W-1:0] cw_data,
    output logic              cr_valid,
    output logic [ADDR_W-1:0] cr_addr,
    input  logic [WORD_W-1:0] cr_rdata,
    output logic              sb_empty,
    output logic              drain_done
);

    sb_entry_t     slots [DEPTH];
    sb_entry_t     head_entry;
    logic [PW-1:0] head_ptr;
    logic [CW-1:0] count;
    logic          full;
    logic          empty;
    logic          push;
    logic          pop;
    logic          ld_fire;
    logic          fwd_hit;
    word_t         fwd_data;
    logic          rmw_rd;
    logic          rmw_wr;
    logic          rsp_valid_q;
    logic          rsp_fwd_q;
    word_t         rsp_data_q;

    // a pending fence or swap is older than any same-cycle store or load
    assign st_ready = !full && !sync_valid;
    assign ld_ready = !sync_valid;
    assign push     = st_valid && st_ready;
    assign ld_fire  = ld_valid && ld_ready;
    assign pop      = !empty && cw_ready;

    tsq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk          (clk),
        .rst          (rst),
        .push_i       (push),
        .push_entry_i (make_entry(st_addr, st_data)),
        .pop_i        (pop),
        .slots_o      (slots),
        .head_o       (head_ptr),
        .count_o      (count),
        .head_entry_o (head_entry),
        .full_o       (full),
        .empty_o      (empty)
    );

    tsq_match #(.DEPTH(DEPTH)) u_match (
        .slots_i (slots),
        .head_i  (head_ptr),
        .count_i (count),
        .addr_i  (ld_addr),
        .hit_o   (fwd_hit),
        .data_o  (fwd_data)
    );

    tsq_sync_ctl u_sync (
        .clk          (clk),
        .rst          (rst),
        .sync_valid_i (sync_valid),
        .sync_rmw_i   (sync_rmw),
        .buf_empty_i  (empty),
        .cw_ready_i   (cw_ready),
        .cr_rdata_i   (cr_rdata),
        .sync_ready_o (sync_ready),
        .drain_done_o (drain_done),
        .rmw_rd_o     (rmw_rd),
        .rmw_wr_o     (rmw_wr),
        .old_word_o   (sync_rdata)
    );

    // cache ports: the swap only runs with an empty queue, so no conflict
    assign cw_valid = rmw_wr || !empty;
    assign cw_addr  = rmw_wr ? sync_addr  : head_entry.addr;
    assign cw_data  = rmw_wr ? sync_wdata : head_entry.data;
    assign cr_valid = rmw_rd || (ld_fire && !fwd_hit);
    assign cr_addr  = rmw_rd ? sync_addr : ld_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_fwd_q   <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= ld_fire;
            rsp_fwd_q   <= fwd_hit;
            rsp_data_q  <= fwd_data;
        end
    end

    assign ld_rvalid = rsp_valid_q;
    assign ld_rdata  = rsp_fwd_q ? rsp_data_q : cr_rdata;
    assign sb_empty  = empty;

endmodule

// File: rtl/tsq_checker.sv
module tsq_checker
    import tsq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned OW = $clog2(DEPTH + 1) + 1
) (
    input logic        clk,
    input logic        rst,
    input logic        st_valid,
    input logic        st_ready,
    input logic        ld_valid,
    input logic        ld_ready,
    input logic        ld_rvalid,
    input logic        sync_valid,
    input logic        sync_ready,
    input logic        cw_valid,
    input logic        cw_ready,
    input logic [ADDR_W-1:0] cw_addr,
    input logic [WORD_W-1:0] cw_data,
    input logic        sb_empty,
    input logic        drain_done
);

    logic [OW-1:0] occ;
    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
        end else begin
            occ <= occ + OW'(st_valid && st_ready) - OW'(cw_valid && cw_ready && !sb_empty);
        end
    end

    // R1
    held_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
        cw_valid && !cw_ready && !sb_empty |=> cw_valid && $stable(cw_addr) && $stable(cw_data));

    // R2
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        occ == OW'(DEPTH) |-> !st_ready);

    // R3
    load_latency_chk: assert property (@(posedge clk) disable iff (rst)
        ld_valid && ld_ready |=> ld_rvalid);

    // R7
    fence_waits_chk: assert property (@(posedge clk) disable iff (rst)
        sync_valid && !sb_empty |-> !sync_ready);

    // R7
    hold_during_sync_chk: assert property (@(posedge clk) disable iff (rst)
        sync_valid |-> !st_ready && !ld_ready);

    // R9
    empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) == sb_empty);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        drain_done == (sync_valid && sync_ready));

endmodule

bind tsq_store_queue tsq_checker #(.DEPTH(DEPTH)) u_tsq_chk (
    .clk        (clk),
    .rst        (rst),
    .st_valid   (st_valid),
    .st_ready   (st_ready),
    .ld_valid   (ld_valid),
    .ld_ready   (ld_ready),
    .ld_rvalid  (ld_rvalid),
    .sync_valid (sync_valid),
    .sync_ready (sync_ready),
    .cw_valid   (cw_valid),
    .cw_ready   (cw_ready),
    .cw_addr    (cw_addr),
    .cw_data    (cw_data),
    .sb_empty   (sb_empty),
    .drain_done (drain_done)
);

// File: tb/tsq_store_queue_bench.sv
module tsq_store_queue_bench;
    import tsq_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic st_valid = 0, ld_valid = 0, sync_valid = 0, sync_rmw = 0, cw_ready = 0;
    logic [ADDR_W-1:0] st_addr = '0, ld_addr = '0, sync_addr = '0;
    logic [WORD_W-1:0] st_data = '0, sync_wdata = '0;
    logic st_ready, ld_ready, ld_rvalid, sync_ready, cw_valid, cr_valid, sb_empty, drain_done;
    logic [WORD_W-1:0] ld_rdata, sync_rdata, cw_data, cr_rdata;
    logic [ADDR_W-1:0] cw_addr, cr_addr;

    tsq_store_queue u_tsq_store_queue (.*);

    // cache model: one-cycle read latency, writes when cw_ready
    logic [WORD_W-1:0] mem [16];
    logic [ADDR_W-1:0] wlog_a [16];
    logic [WORD_W-1:0] wlog_d [16];
    int wn;
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) mem[i] <= 32'hA000_0000 + i;
            wn <= 0;
        end else begin
            if (cr_valid) cr_rdata <= mem[cr_addr[3:0]];
            if (cw_valid && cw_ready) begin
                mem[cw_addr[3:0]] <= cw_data;
                wlog_a[wn] <= cw_addr;
                wlog_d[wn] <= cw_data;
                wn <= wn + 1;
            end
        end
    end

    int ntests = 0, nfail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_store(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        st_valid = 1; st_addr = {22'b0, a}; st_data = d;
        #1;
        while (!st_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        st_valid = 0;
    endtask

    task automatic do_load(input logic [7:0] a, input logic [31:0] exp, input bit hit, input string req);
        @(negedge clk);
        ld_valid = 1; ld_addr = {22'b0, a};
        #1;
        while (!ld_ready) begin @(negedge clk); #1; end
        chk(cr_valid == !hit, req, 32'(cr_valid), 32'(!hit));
        @(posedge clk); #1;
        ld_valid = 0;
        @(negedge clk);
        chk(ld_rvalid && ld_rdata == exp, req, ld_rdata, exp);
    endtask

    typedef struct packed {
        logic        ld;
        logic        hit;
        logic [7:0]  a;
        logic [31:0] v;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 1'b0, 8'h03, 32'h0000_0011},  // store
        '{1'b0, 1'b0, 8'h05, 32'h0000_0022},  // store
        '{1'b1, 1'b1, 8'h03, 32'h0000_0011},  // R4 forward
        '{1'b1, 1'b0, 8'h07, 32'hA000_0007},  // R3 R6 bypass to cache
        '{1'b0, 1'b0, 8'h03, 32'h0000_0033},  // store, same address again
        '{1'b1, 1'b1, 8'h03, 32'h0000_0033},  // R5 youngest wins
        '{1'b1, 1'b1, 8'h05, 32'h0000_0022},  // R4 forward
        '{1'b0, 1'b0, 8'h09, 32'h0000_0044}   // store, queue now full
    };

    localparam logic [7:0]  EXP_A [4] = '{8'h03, 8'h05, 8'h03, 8'h09};
    localparam logic [31:0] EXP_D [4] = '{32'h11, 32'h22, 32'h33, 32'h44};

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            ntests++; nfail++;
            $display("FAIL R10 watchdog act=%h exp=%h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R10 reset state
        chk(sb_empty == 1, "R10 empty", 32'(sb_empty), 1);
        chk(cw_valid == 0, "R10 cw_valid", 32'(cw_valid), 0);
        chk(ld_rvalid == 0, "R10 ld_rvalid", 32'(ld_rvalid), 0);
        chk(st_ready == 1, "R10 st_ready", 32'(st_ready), 1);

        // table walk with the cache refusing writes
        for (int i = 0; i < 8; i++) begin
            if (VEC[i].ld) do_load(VEC[i].a, VEC[i].v, VEC[i].hit, "R3/R4/R5/R6 table");
            else do_store(VEC[i].a, VEC[i].v);
        end

        // R2 full queue refuses a fifth store
        @(negedge clk);
        st_valid = 1; st_addr = 30'h0F; st_data = 32'hDEAD;
        #1;
        chk(st_ready == 0, "R2 st_ready when full", 32'(st_ready), 0);
        chk(sb_empty == 0, "R9 empty while full", 32'(sb_empty), 0);
        @(posedge clk); #1;
        st_valid = 0;

        // R7 fence while queue holds entries
        @(negedge clk);
        sync_valid = 1; sync_rmw = 0;
        #1;
        chk(sync_ready == 0, "R7 fence held", 32'(sync_ready), 0);
        chk(!st_ready && !ld_ready, "R7 access blocked", {st_ready, ld_ready}, 0);
        cw_ready = 1;
        for (int c = 0; c < 20 && !sync_ready; c++) begin @(negedge clk); #1; end
        chk(sync_ready == 1, "R7 fence released", 32'(sync_ready), 1);
        chk(drain_done == 1, "R9 drain_done", 32'(drain_done), 1);
        chk(wn == 4, "R7 drained before release", wn, 4);
        @(posedge clk); #1;
        sync_valid = 0;
        @(negedge clk);
        chk(drain_done == 0, "R9 pulse ends", 32'(drain_done), 0);
        // R1 order of writes; R2 the refused store never appears
        for (int i = 0; i < 4; i++)
            chk(wlog_a[i] == {22'b0, EXP_A[i]} && wlog_d[i] == EXP_D[i], "R1 drain order", wlog_d[i], EXP_D[i]);

        // R11 same-cycle store and load to the same address
        cw_ready = 0;
        @(negedge clk);
        st_valid = 1; st_addr = 30'h06; st_data = 32'h55;
        ld_valid = 1; ld_addr = 30'h06;
        #1;
        chk(cr_valid == 1, "R11 load misses same-cycle store", 32'(cr_valid), 1);
        @(posedge clk); #1;
        st_valid = 0; ld_valid = 0;
        @(negedge clk);
        chk(ld_rvalid && ld_rdata == 32'hA000_0006, "R11 cache old word", ld_rdata, 32'hA000_0006);

        // R11 forward from the entry draining in the same cycle
        @(negedge clk);
        cw_ready = 1; ld_valid = 1; ld_addr = 30'h06;
        #1;
        chk(cr_valid == 0 && cw_valid == 1, "R11 hit during drain", {cr_valid, cw_valid}, 32'h1);
        @(posedge clk); #1;
        ld_valid = 0;
        @(negedge clk);
        chk(ld_rvalid && ld_rdata == 32'h55, "R11 forwarded while draining", ld_rdata, 32'h55);
        chk(sb_empty == 1, "R9 empty after drain", 32'(sb_empty), 1);

        // R8 swap after a queued store to the same word
        cw_ready = 0;
        do_store(8'h03, 32'h77);
        @(negedge clk);
        sync_valid = 1; sync_rmw = 1; sync_addr = 30'h03; sync_wdata = 32'h99;
        #1;
        chk(sync_ready == 0, "R8 swap waits for drain", 32'(sync_ready), 0);
        cw_ready = 1;
        for (int c = 0; c < 20 && !sync_ready; c++) begin @(negedge clk); #1; end
        chk(sync_ready && sync_rdata == 32'h77, "R8 old word", sync_rdata, 32'h77);
        chk(cw_valid && cw_addr == 30'h03 && cw_data == 32'h99, "R8 swap write", cw_data, 32'h99);
        @(posedge clk); #1;
        sync_valid = 0; sync_rmw = 0;
        do_load(8'h03, 32'h99, 1'b0, "R3 R8 read after swap");
        chk(wn == 7, "R1 write count", wn, 7);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule